// File: doc/BRIEF.md
# Sticky Alarm Monitor with Output Kill

This block sits beside a data converter's input path and gathers fault reports from the error detectors around it: a PLL lock level, one parity-error strobe per data lane, a clock-fault strobe and a FIFO-collision strobe. Each fault is held in its own sticky status bit until software clears it. Status bits that are set and not masked drive one registered, active-high interrupt line.

Two of the alarms, clock fault and FIFO collision, can each be armed to force the converter output off. While an armed alarm bit stays set, the output stays off, even if both transmit enables are high. Once software clears the bit, control of the output goes back to the transmit enables.

The parity lanes have two modes. In per-word mode each of the four lanes reports on its own data word. In per-edge mode only two lanes are used: lane 0 reports on the 32-bit capture taken on the rising data-clock edge, and lane 1 reports on the capture taken on the falling edge. A small register port gives read access to status, write-zero clearing of status, and write access to the mask and kill-enable fields. All ports are plain control and status signals. The block has no streaming interface, so no valid/ready handshake applies.

Top module: `alarm_guard`

## Requirements
- R1: Status bit 0 is set in every cycle in which `pll_locked` is sampled low. After lock returns, the bit stays set until it is cleared.
- R2: With `par_single` low, a strobe on `par_err[k]` sets status bit 1+k, for k = 0..3.
- R3: With `par_single` high, `par_err[0]` (rising-edge capture) sets bit 1 and `par_err[1]` (falling-edge capture) sets bit 2. Strobes on `par_err[2]` and `par_err[3]` are ignored.
- R4: A `clk_fault` strobe sets status bit 5, and a `fifo_coll` strobe sets status bit 6.
- R5: A write to address 0 clears every status bit written as 0 and leaves every bit written as 1 unchanged. A set bit with no clear stays set.
- R6: If a new event and a clear reach the same bit in the same cycle, the bit stays set. A cause that persists sets its bit again after each clear.
- R7: Address 1 holds the mask, where 1 means masked. `irq` is the registered OR of the set, unmasked status bits. It rises one cycle after such a bit is set and falls one cycle after the last one is cleared.
- R8: Address 2 holds the kill enables: bit 0 arms the clock alarm and bit 1 arms the FIFO-collision alarm. While an armed alarm's status bit is set, `dac_out_en` is low regardless of `tx_en_pin` and `tx_en_sw`.
- R9: When no armed alarm bit is set, `dac_out_en` equals `tx_en_pin` AND `tx_en_sw`.
- R10: After reset, status reads 0, the mask reads 7'h7F (all alarms masked), the kill enables read 0, and `irq` is low.
- R11: Reads are combinational on `reg_addr`. Address 3 reads 0, and unused bits of address 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | PLL lock level, sampled every cycle |
| par_single | input | 1 | 1 = per-edge parity mode, 0 = per-word mode |
| par_err | input | LANES | Per-lane parity error strobes |
| clk_fault | input | 1 | Clock fault strobe |
| fifo_coll | input | 1 | FIFO collision strobe |
| tx_en_pin | input | 1 | Hardware transmit enable |
| tx_en_sw | input | 1 | Software transmit enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | LANES+3 | Register write data |
| reg_rdata | output | LANES+3 | Register read data |
| irq | output | 1 | Registered alarm interrupt, active high |
| dac_out_en | output | 1 | Converter output enable |

## Verification
The assertions check on every cycle that an event always leaves its bit set and that a bit with no clear never drops. They also check that a PLL unlock is held in its bit, that the unused lanes in per-edge mode stay quiet, that `irq` stays low after a fully masked cycle, and that an armed, set alarm or a low transmit enable keeps the output off. The bench's scenarios are needed to show the exact bit each input maps to, the write-one-keeps rule, the one-cycle delays of `irq` rising and falling, the hand-back of output control after a clear, and the reset values seen through the register port.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_KILL   = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  localparam int KILL_W = 2;
endpackage

// File: rtl/alarm_capture.sv
module alarm_capture #(
  parameter int LANES = 4,
  localparam int NA = LANES + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_locked,
  input  logic             par_single,
  input  logic [LANES-1:0] par_err,
  input  logic             clk_fault,
  input  logic             fifo_coll,
  input  logic [NA-1:0]    clr,
  output logic [NA-1:0]    status
);
  logic [NA-1:0] ev;

  assign ev[0]       = ~pll_locked;
  assign ev[LANES+1] = clk_fault;
  assign ev[LANES+2] = fifo_coll;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < 2) begin : g_used
      assign ev[1+k] = par_err[k];
    end else begin : g_word_only
      assign ev[1+k] = par_err[k] & ~par_single;
      AST_SINGLE_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_single && !status[1+k]) |=> !status[1+k]); // R3
    end
  end

  for (genvar i = 0; i < NA; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     status[i] <= 1'b0;
      else if (ev[i]) status[i] <= 1'b1;
      else if (clr[i]) status[i] <= 1'b0;
    end
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> status[i]); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr[i]) |=> status[i]); // R5
  end

  AST_PLL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> status[0]); // R1
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int NA = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NA-1:0]     reg_wdata,
  input  logic [NA-1:0]     status,
  output logic [NA-1:0]     clr,
  output logic [NA-1:0]     mask,
  output logic [KILL_W-1:0] kill_en,
  output logic [NA-1:0]     reg_rdata
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  assign clr = (reg_wr && addr == ADDR_STATUS) ? ~reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '1;
      kill_en <= '0;
    end else if (reg_wr) begin
      if (addr == ADDR_MASK) mask <= reg_wdata;
      if (addr == ADDR_KILL) kill_en <= reg_wdata[KILL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (addr)
      ADDR_STATUS: reg_rdata = status;
      ADDR_MASK:   reg_rdata = mask;
      ADDR_KILL:   reg_rdata[KILL_W-1:0] = kill_en;
      default:     reg_rdata = '0;
    endcase
  end

  AST_CLEAR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> (clr == '0)); // R5
endmodule

// File: rtl/alarm_out.sv
module alarm_out
  import alarm_pkg::*;
#(
  parameter int NA = 7,
  parameter int CLK_IDX = 5,
  parameter int FIFO_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NA-1:0]     status,
  input  logic [NA-1:0]     mask,
  input  logic [KILL_W-1:0] kill_en,
  input  logic              tx_en_pin,
  input  logic              tx_en_sw,
  output logic              irq,
  output logic              dac_out_en
);
  logic kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & ~mask);
  end

  assign kill       = (kill_en[0] & status[CLK_IDX]) | (kill_en[1] & status[FIFO_IDX]);
  assign dac_out_en = tx_en_pin & tx_en_sw & ~kill;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask) |-> !irq); // R7
  AST_KILL_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en[0] && status[CLK_IDX]) |-> !dac_out_en); // R8
  AST_KILL_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en[1] && status[FIFO_IDX]) |-> !dac_out_en); // R8
  AST_TX_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en_pin && tx_en_sw) |-> !dac_out_en); // R9
endmodule

// File: rtl/alarm_guard.sv
module alarm_guard #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_locked,
  input  logic             par_single,
  input  logic [LANES-1:0] par_err,
  input  logic             clk_fault,
  input  logic             fifo_coll,
  input  logic             tx_en_pin,
  input  logic             tx_en_sw,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [LANES+2:0] reg_wdata,
  output logic [LANES+2:0] reg_rdata,
  output logic             irq,
  output logic             dac_out_en
);
  localparam int NA = LANES + 3;

  logic [NA-1:0] status, clr, mask;
  logic [alarm_pkg::KILL_W-1:0] kill_en;

  alarm_capture #(.LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .par_single(par_single),
    .par_err(par_err), .clk_fault(clk_fault), .fifo_coll(fifo_coll),
    .clr(clr), .status(status)
  );

  alarm_regs #(.NA(NA)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .clr(clr), .mask(mask),
    .kill_en(kill_en), .reg_rdata(reg_rdata)
  );

  alarm_out #(.NA(NA), .CLK_IDX(LANES+1), .FIFO_IDX(LANES+2)) u_out (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .kill_en(kill_en),
    .tx_en_pin(tx_en_pin), .tx_en_sw(tx_en_sw), .irq(irq), .dac_out_en(dac_out_en)
  );
endmodule

// File: tb/alarm_guard_test.sv
module alarm_guard_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pll_locked = 1'b1, par_single = 1'b0, clk_fault = 1'b0, fifo_coll = 1'b0;
  logic [3:0] par_err = '0;
  logic tx_en_pin = 1'b1, tx_en_sw = 1'b1, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [6:0] reg_wdata = '0, reg_rdata;
  logic irq, dac_out_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  alarm_guard uut (.*);

  // stimulus {locked, single, par[3:0], clk_fault, fifo} , expected status
  localparam logic [15:0] VEC [10] = '{
    {8'b0_0_0000_0_0, 8'h01},  // R1
    {8'b1_0_0001_0_0, 8'h02},  // R2
    {8'b1_0_1000_0_0, 8'h10},  // R2
    {8'b1_0_0110_0_0, 8'h0C},  // R2
    {8'b1_1_0001_0_0, 8'h02},  // R3
    {8'b1_1_0010_0_0, 8'h04},  // R3
    {8'b1_1_1100_0_0, 8'h00},  // R3
    {8'b1_1_1111_0_0, 8'h06},  // R3
    {8'b1_0_0000_1_0, 8'h20},  // R4
    {8'b1_0_0000_0_1, 8'h40}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [6:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] s);
    {pll_locked, par_single, par_err, clk_fault, fifo_coll} = s;
    cyc();
    pll_locked = 1'b1; par_err = '0; clk_fault = 1'b0; fifo_coll = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [6:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    reg_addr = 2'd0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    rd("R10 status", 2'd0, 7'h00);
    rd("R10 mask", 2'd1, 7'h7F);
    rd("R10 kill", 2'd2, 7'h00);
    chk("R10 irq", irq, 0);
    chk("R9 out_en", dac_out_en, 1);

    for (int i = 0; i < 10; i++) begin
      pulse(VEC[i][15:8]);
      par_single = 1'b0;
      rd($sformatf("R1-4 vec%0d", i), 2'd0, VEC[i][6:0]);
      wr_reg(2'd0, 7'h00);
      rd("R5 clear", 2'd0, 7'h00);
    end

    // R5 write-one keeps
    pulse(8'b1_0_0000_1_1);
    rd("R4 both", 2'd0, 7'h60);
    wr_reg(2'd0, 7'h20);
    rd("R5 keep bit", 2'd0, 7'h20);
    wr_reg(2'd0, 7'h00);

    // R6 event beats clear
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 7'h00; fifo_coll = 1'b1;
    cyc();
    reg_wr = 1'b0; fifo_coll = 1'b0;
    rd("R6 same cycle", 2'd0, 7'h40);
    wr_reg(2'd0, 7'h00);
    pll_locked = 1'b0;
    cyc();
    wr_reg(2'd0, 7'h00);
    rd("R6 persist", 2'd0, 7'h01);
    pll_locked = 1'b1;
    wr_reg(2'd0, 7'h00);
    rd("R6 gone", 2'd0, 7'h00);

    // R7 interrupt timing
    wr_reg(2'd1, 7'h5F);
    rd("R11 mask rb", 2'd1, 7'h5F);
    pulse(8'b1_0_0000_1_0);
    chk("R7 irq lag", irq, 0);
    cyc();
    chk("R7 irq rise", irq, 1);
    wr_reg(2'd0, 7'h00);
    chk("R7 irq hold", irq, 1);
    cyc();
    chk("R7 irq fall", irq, 0);
    pulse(8'b1_0_0000_0_1);
    cyc();
    chk("R7 masked", irq, 0);
    wr_reg(2'd0, 7'h00);

    // R8 / R9 output kill
    wr_reg(2'd2, 7'h01);
    pulse(8'b1_0_0000_1_0);
    chk("R8 clock kill", dac_out_en, 0);
    wr_reg(2'd0, 7'h00);
    chk("R9 release", dac_out_en, 1);
    pulse(8'b1_0_0000_0_1);
    chk("R8 fifo unarmed", dac_out_en, 1);
    wr_reg(2'd2, 7'h7E);
    rd("R11 kill rb", 2'd2, 7'h02);
    chk("R8 fifo kill", dac_out_en, 0);
    wr_reg(2'd0, 7'h00);
    tx_en_sw = 1'b0; #1;
    chk("R9 sw off", dac_out_en, 0);
    tx_en_sw = 1'b1; tx_en_pin = 1'b0; #1;
    chk("R9 pin off", dac_out_en, 0);
    tx_en_pin = 1'b1;
    rd("R11 addr3", 2'd3, 7'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule